// File: doc/BRIEF.md
# Sigma-Delta IIR Re-Modulator

This block takes a signed multi-bit sample every clock, typically the wide sum produced by a bitstream FIR stage, and returns one bit per clock. The bit stream is low-pass filtered and carries the input's level as a pulse density. A single loop does both jobs. A leaky integrator adds the scaled input and subtracts the fed-back output level. A one-bit quantizer sits in the feedback path and acts as a one-cycle delay. The signal therefore sees a first-order low-pass with gain v and one cycle of delay, and the quantization error is shaped by a first difference over the same pole.

The two loop constants are powers of two, set by shift parameters: v = 2^V_SHIFT scales the input and u = 2^U_SHIFT scales the feedback. The loop therefore has no multipliers. The quantizer is a two-state machine. State LVL_POS drives output bit 1, which stands for +full scale. State LVL_NEG drives output bit 0, which stands for -full scale. The machine has four transitions, all evaluated on the sign of the next integrator value:
- HOLD_POS: stay in LVL_POS while that value is non-negative.
- DROP: go from LVL_POS to LVL_NEG when it is negative.
- HOLD_NEG: stay in LVL_NEG while it is negative.
- RISE: go from LVL_NEG to LVL_POS when it is non-negative.

Reset puts the machine in LVL_POS and clears the integrator.

Top module: `sdr_remod`

## Requirements
- R1: While rst is high and on the first cycle after it is released, the integrator holds 0 and bit_out is 1. This applies equally when reset is asserted in the middle of a run.
- R2: bit_out is 1 exactly when the integrator value w[k] is non-negative, and 0 when it is negative. A change of x_in first affects bit_out on the cycle after it is sampled.
- R3: On each clock, w[k+1] = w[k] + x_in·2^V_SHIFT − s·2^(IN_W−1+U_SHIFT). Here s is +1 when bit_out is 1 and −1 when it is 0.
- R4: Hold x_in constant for 32 cycles. Over the next 256 cycles, the number of 1 bits is within ±2 of 128·(1 + x_in·2^(V_SHIFT−U_SHIFT)/2^(IN_W−1)).
- R5: The integrator is ACC_W = IN_W + max(U_SHIFT,V_SHIFT) + 2 bits wide. A sum outside its signed range clamps to the nearest limit and never wraps.
- R6: After reset with x_in held at 0, bit_out alternates 1,0,1,0,... starting with 1.
- R7: When V_SHIFT ≤ U_SHIFT, every input in the full signed range keeps w within [−2^(IN_W+U_SHIFT), 2^(IN_W+U_SHIFT)), so the clamp is never reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | IN_W | Signed two's-complement input sample, one per clock |
| bit_out | output | 1 | Output bit stream: 1 = +full scale, 0 = −full scale |

## Verification
The only visible state is the sign of the integrator. A wrong integrator value therefore shows up at bit_out only when it moves w across zero. This usually happens within a few cycles, because the loop keeps w within about two feedback steps of zero. A bit-exact model run in lockstep catches such a divergence on the first cycle it reaches the output. A wrong gain or shift that still leaves the bit pattern plausible is caught by the pulse-density count over 256 cycles. A wrapping integrator is exposed with an overdriven parameter set: wrapping would flip the saturated output from all ones to zeros at once, and it would change the exact cycle on which the output recovers after the input reverses.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    // Quantizer level: the encoding is the output bit itself.
    typedef enum logic {
        LVL_NEG = 1'b0,
        LVL_POS = 1'b1
    } lvl_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_scale.sv
// Sign-extend a sample and multiply it by 2^SHIFT.
module sdr_scale #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12,
    parameter int SHIFT = 1
) (
    input  logic signed [IN_W-1:0]  x_i,
    output logic signed [OUT_W-1:0] y_o
);
    logic signed [OUT_W-1:0] ext;

    always_comb begin
        ext = {{(OUT_W-IN_W){x_i[IN_W-1]}}, x_i};
        y_o = ext <<< SHIFT;
    end
endmodule

// File: rtl/sdr_accum.sv
// Saturating integrator: acc <= clamp(acc + step).
module sdr_accum #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] step_i,
    output logic signed [W-1:0] acc_o,
    output logic signed [W-1:0] acc_next_o
);
    localparam logic signed [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_wide;

    always_comb begin
        sum_wide = {step_i[W-1], step_i} + {acc_o[W-1], acc_o};
        if (sum_wide[W] != sum_wide[W-1]) begin
            acc_next_o = sum_wide[W] ? ACC_MIN : ACC_MAX;
        end else begin
            acc_next_o = sum_wide[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
        end else begin
            acc_o <= acc_next_o;
        end
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) rst |=> (acc_o == '0)); // R1
    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        !step_i[W-1] |=> (acc_o >= $past(acc_o))); // R5
    AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
        step_i[W-1] |=> (acc_o <= $past(acc_o))); // R5
endmodule

// File: rtl/sdr_quant_fsm.sv
// One-bit quantizer as a two-state machine driven by the sign of the next
// integrator value.
module sdr_quant_fsm
    import sdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sign_i,   // 1 when the next integrator value is negative
    output lvl_e lvl_o,
    output logic bit_o
);
    lvl_e state_q;
    lvl_e state_d;

    always_comb begin
        unique case (state_q)
            LVL_POS: state_d = sign_i ? LVL_NEG : LVL_POS;  // DROP / HOLD_POS
            LVL_NEG: state_d = sign_i ? LVL_NEG : LVL_POS;  // HOLD_NEG / RISE
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LVL_POS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        lvl_o = state_q;
        bit_o = (state_q == LVL_POS);
    end

    AST_RESET_POS: assert property (@(posedge clk) rst |=> bit_o); // R1
    AST_FOLLOW_SIGN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bit_o == !$past(sign_i))); // R2
endmodule

// File: rtl/sdr_remod.sv
// First-order sigma-delta IIR re-modulator.
module sdr_remod
    import sdr_pkg::*;
#(
    parameter int IN_W    = 8,
    parameter int U_SHIFT = 2,
    parameter int V_SHIFT = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] x_in,
    output logic                   bit_out
);
    localparam int MAX_SH = max_of(U_SHIFT, V_SHIFT);
    localparam int ACC_W  = IN_W + MAX_SH + 2;
    localparam logic signed [ACC_W-1:0] FB_POS = ACC_W'(1 << (IN_W - 1 + U_SHIFT));
    localparam logic signed [ACC_W-1:0] FB_NEG = -FB_POS;

    logic signed [ACC_W-1:0] x_scaled;
    logic signed [ACC_W-1:0] fb_term;
    logic signed [ACC_W-1:0] step;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    lvl_e                    lvl;

    sdr_scale #(
        .IN_W (IN_W),
        .OUT_W(ACC_W),
        .SHIFT(V_SHIFT)
    ) u_scale (
        .x_i(x_in),
        .y_o(x_scaled)
    );

    always_comb begin
        fb_term = (lvl == LVL_POS) ? FB_POS : FB_NEG;
        step    = x_scaled - fb_term;
    end

    sdr_accum #(
        .W(ACC_W)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step),
        .acc_o     (acc_q),
        .acc_next_o(acc_d)
    );

    sdr_quant_fsm u_quant (
        .clk   (clk),
        .rst   (rst),
        .sign_i(acc_d[ACC_W-1]),
        .lvl_o (lvl),
        .bit_o (bit_out)
    );

    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
        bit_out == !acc_q[ACC_W-1]); // R2

    generate
        if (V_SHIFT <= U_SHIFT) begin : g_bounded
            localparam logic signed [ACC_W-1:0] BND_HI = ACC_W'(1 << (IN_W + U_SHIFT));
            localparam logic signed [ACC_W-1:0] BND_LO = -BND_HI;
            AST_BOUND: assert property (@(posedge clk) disable iff (rst)
                (acc_q >= BND_LO) && (acc_q < BND_HI)); // R7
        end
    endgenerate
endmodule

// File: tb/tb_sdr_remod.sv
`timescale 1ns/1ps
module tb_sdr_remod;
    localparam int IN_W = 8;
    localparam int FS   = 1 << (IN_W - 1);
    // default instance: V_SHIFT=1, U_SHIFT=2, ACC_W=12
    localparam int D_VS = 1;
    localparam int D_FB = FS << 2;
    localparam int D_HI = 2047;
    localparam int D_LO = -2048;
    // overdriven instance: V_SHIFT=4, U_SHIFT=0, ACC_W=14
    localparam int H_VS = 4;
    localparam int H_FB = FS;
    localparam int H_HI = 8191;
    localparam int H_LO = -8192;

    localparam int N_VEC = 7;
    localparam int VEC_X[N_VEC]    = '{0, 64, -64, 127, -128, 32, -100};
    localparam int VEC_ONES[N_VEC] = '{128, 160, 96, 191, 64, 144, 78};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [IN_W-1:0] x = '0;
    logic y_d;
    logic y_h;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_wd, m_wh;
    bit m_yd, m_yh;

    always #2.5 clk = ~clk;

    sdr_remod #(.IN_W(IN_W), .U_SHIFT(2), .V_SHIFT(1)) dut (
        .clk(clk), .rst(rst), .x_in(x), .bit_out(y_d));

    sdr_remod #(.IN_W(IN_W), .U_SHIFT(0), .V_SHIFT(4)) dut_hot (
        .clk(clk), .rst(rst), .x_in(x), .bit_out(y_h));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mdl_next(input int w, input bit y, input int xv,
                                    input int vs, input int fb, input int hi, input int lo);
        int s;
        s = w + xv * (1 << vs) - (y ? fb : -fb);
        if (s > hi) s = hi;
        if (s < lo) s = lo;
        return s;
    endfunction

    task automatic mdl_reset();
        m_wd = 0; m_yd = 1'b1;
        m_wh = 0; m_yh = 1'b1;
    endtask

    // Called at a falling edge: compare outputs, drive x, advance models.
    task automatic cycle(input int xv);
        chk(y_d == m_yd, "R2 R3 model (default)", int'(y_d), int'(m_yd));
        chk(y_h == m_yh, "R3 R5 model (overdriven)", int'(y_h), int'(m_yh));
        x = IN_W'(xv);
        m_wd = mdl_next(m_wd, m_yd, xv, D_VS, D_FB, D_HI, D_LO);
        m_yd = (m_wd >= 0);
        m_wh = mdl_next(m_wh, m_yh, xv, H_VS, H_FB, H_HI, H_LO);
        m_yh = (m_wh >= 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(y_d == 1'b1, "R1 reset level (default)", int'(y_d), 1);
        chk(y_h == 1'b1, "R1 reset level (overdriven)", int'(y_h), 1);
        rst = 1'b0;
        mdl_reset();

        // R6: zero input alternates starting with 1
        for (int i = 0; i < 8; i++) begin
            chk(y_d == ((i % 2) == 0), "R6 zero-input pattern", int'(y_d), int'((i % 2) == 0));
            cycle(0);
        end

        // R4: density table
        for (int v = 0; v < N_VEC; v++) begin
            int ones;
            int diff;
            repeat (32) cycle(VEC_X[v]);
            ones = 0;
            for (int k = 0; k < 256; k++) begin
                ones += int'(y_d);
                cycle(VEC_X[v]);
            end
            diff = ones - VEC_ONES[v];
            chk((diff <= 2) && (diff >= -2), "R4 pulse density", ones, VEC_ONES[v]);
        end

        // R5: overdriven instance saturates and holds 1 instead of wrapping
        repeat (12) cycle(127);
        for (int i = 0; i < 6; i++) begin
            chk(y_h == 1'b1, "R5 saturated high", int'(y_h), 1);
            cycle(127);
        end
        // Reversal: 8191 -> 6015 -> 3839 -> 1663 -> -513
        for (int i = 0; i < 5; i++) begin
            chk(y_h == (i < 4), "R5 recovery from clamp", int'(y_h), int'(i < 4));
            cycle(-128);
        end

        // R1: mid-run reset clears the integrator
        repeat (5) cycle(-77);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(y_d == 1'b1, "R1 mid-run reset (default)", int'(y_d), 1);
        chk(y_h == 1'b1, "R1 mid-run reset (overdriven)", int'(y_h), 1);
        rst = 1'b0;
        mdl_reset();
        for (int i = 0; i < 6; i++) begin
            chk(y_d == ((i % 2) == 0), "R1 R6 cleared state pattern", int'(y_d), int'((i % 2) == 0));
            chk(y_h == ((i % 2) == 0), "R1 R6 cleared state pattern (overdriven)", int'(y_h), int'((i % 2) == 0));
            cycle(0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule